// File: doc/BRIEF.md
# IR Carrier Frequency Sensor

This block measures the carrier riding on a modulated infrared input. The raw line is brought into the clock domain through a synchronizer, and every rising edge of the synchronized level both closes one carrier cycle and opens the next. Between two rising edges the block counts ticks of a 2 MHz reference, derived from the system clock by a divider, over the whole cycle and over the part of it where the line was high.

When a cycle closes, both counts are written into two result registers. The period result has a valid flag in its top bit and the tick count below it. The high-time result holds the tick count of the high portion. Software derives the carrier frequency as 2,000,000 divided by the period count and the duty cycle in percent as high count times 100 divided by the period count. A period count of zero means that no carrier was measured. Reading the period result is signalled by a one-cycle strobe, which clears the valid flag. Measurement runs only while the carrier-detect enable and the demodulation-mode select are both high.

Top module: `ircs_carrier_sense`

## Requirements
- R1: After reset both `period_reg` and `high_reg` read 0.
- R2: When two rising edges of `ir_raw` are N clock cycles apart, and the first was not the arming edge, `period_reg[6:0]` becomes floor(N / TICK_DIV) and `period_reg[7]` (the valid flag) becomes 1, provided that count is between 1 and 127.
- R3: For the same cycle, with `ir_raw` high for H cycles after the opening edge, `high_reg[6:0]` becomes floor(H / TICK_DIV), capped at 127, and `high_reg[7]` is always 0.
- R4: The first rising edge after the block becomes active (both enables high) only starts a measurement and leaves the result registers unchanged.
- R5: A completed cycle whose period count is zero writes a count of 0 with the valid flag clear in `period_reg`.
- R6: A completed cycle whose period count would exceed 127 writes 127 with the valid flag clear in `period_reg`, and the high count saturates at 127.
- R7: A one-cycle pulse on `rd_clr` with no measurement completing in that cycle clears `period_reg[7]` and leaves `period_reg[6:0]` and `high_reg` unchanged.
- R8: While `det_en` or `demod_en` is low, edges on `ir_raw` do not change either result register, and the measurement in progress is dropped.
- R9: A closing rising edge on `ir_raw` shows up in the result registers at the third rising clock edge after `ir_raw` goes high, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_raw | input | 1 | Modulated IR line, asynchronous to clk |
| det_en | input | 1 | Carrier-detect enable |
| demod_en | input | 1 | Demodulation mode selected |
| rd_clr | input | 1 | Strobe marking a read of the period result; clears the valid flag |
| period_reg | output | CNT_W+1 | Valid flag in the top bit, period tick count below |
| high_reg | output | CNT_W+1 | High-portion tick count, top bit zero |

## Verification
The bench builds the block with TICK_DIV set to 4, so one reference tick lasts four clock cycles. At that setting the 127-tick ceiling is crossed after 512 cycles. Overflow of the period count and saturation of the high count therefore come within reach alongside many short random carrier cycles. The sub-tick period that must read as no carrier is only three cycles long. The width and synchronizer depth keep their defaults, so the 7-bit count and the three-edge latency are checked exactly as shipped.

// File: rtl/ircs_pkg.sv
package ircs_pkg;

    // measurement phase of the period meter
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_TRACK = 1'b1
    } ircs_phase_e;

    // default build values: 100 MHz clock divided to a 2 MHz tick
    localparam int unsigned IRCS_DEF_TICK_DIV = 50;
    localparam int unsigned IRCS_DEF_CNT_W    = 7;
    localparam int unsigned IRCS_DEF_SYNC     = 2;

endpackage

// File: rtl/ircs_sync.sv
module ircs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl_prev,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_q, st_d;
    logic     level;

    always_comb begin
        st_d       = st_q;
        st_d.chain = (st_q.chain << 1) | STAGES'(din);
        st_d.prev  = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = st_q.chain[STAGES-1];
    assign lvl_prev = st_q.prev;
    assign rise     = level & ~st_q.prev;

endmodule

// File: rtl/ircs_tick.sv
module ircs_tick #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] cnt_q, cnt_d;

    assign tick = (cnt_q == DIV_W'(DIV - 1));

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ircs_meter.sv
module ircs_meter
    import ircs_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             rise,
    input  logic             lvl_prev,
    input  logic             tick,
    output logic             done,
    output logic [CNT_W-1:0] fin_per,
    output logic [CNT_W-1:0] fin_high,
    output logic             fin_ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        ircs_phase_e      phase;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
        logic             ovf;
    } meter_st_t;

    meter_st_t st_q, st_d;

    always_comb begin
        // counts as they stand once this cycle's tick is applied
        fin_per  = st_q.per;
        fin_high = st_q.high;
        fin_ovf  = st_q.ovf;
        if (tick) begin
            if (st_q.per == CNT_MAX) fin_ovf = 1'b1;
            else                     fin_per = st_q.per + CNT_W'(1);
            if (lvl_prev && (st_q.high != CNT_MAX))
                fin_high = st_q.high + CNT_W'(1);
        end

        st_d = st_q;
        done = 1'b0;
        if (!active) begin
            st_d = '0;
        end else if (rise) begin
            done       = (st_q.phase == PH_TRACK);
            st_d.phase = PH_TRACK;
            st_d.per   = '0;
            st_d.high  = '0;
            st_d.ovf   = 1'b0;
        end else if (st_q.phase == PH_TRACK) begin
            st_d.per  = fin_per;
            st_d.high = fin_high;
            st_d.ovf  = fin_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: an overflowed run holds the period counter at its ceiling
    a_r6_ovf_pins_max: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> (st_q.per == CNT_MAX));

    // R8: dropping either enable abandons the run on the next cycle
    a_r8_drop_run: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.phase == PH_IDLE));

endmodule

// File: rtl/ircs_carrier_sense.sv
module ircs_carrier_sense
    import ircs_pkg::*;
#(
    parameter int unsigned TICK_DIV    = IRCS_DEF_TICK_DIV,
    parameter int unsigned CNT_W       = IRCS_DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = IRCS_DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_raw,
    input  logic             det_en,
    input  logic             demod_en,
    input  logic             rd_clr,
    output logic [CNT_W:0]   period_reg,
    output logic [CNT_W:0]   high_reg
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
    } result_t;

    logic             active;
    logic             lvl_prev;
    logic             rise;
    logic             tick;
    logic             done;
    logic [CNT_W-1:0] fin_per;
    logic [CNT_W-1:0] fin_high;
    logic             fin_ovf;
    result_t          res_q, res_d;

    assign active = det_en & demod_en;

    ircs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ir_raw),
        .lvl_prev (lvl_prev),
        .rise     (rise)
    );

    ircs_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rise),
        .tick  (tick)
    );

    ircs_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .rise     (rise),
        .lvl_prev (lvl_prev),
        .tick     (tick),
        .done     (done),
        .fin_per  (fin_per),
        .fin_high (fin_high),
        .fin_ovf  (fin_ovf)
    );

    always_comb begin
        res_d = res_q;
        if (done) begin
            // a completing measurement takes precedence over a clear
            res_d.per   = fin_ovf ? CNT_MAX : fin_per;
            res_d.high  = fin_high;
            res_d.valid = !fin_ovf && (fin_per != '0);
        end else if (rd_clr) begin
            res_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign period_reg = {res_q.valid, res_q.per};
    assign high_reg   = {1'b0, res_q.high};

    // R5: a flagged result never carries a zero period
    a_r5_valid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        period_reg[CNT_W] |-> (period_reg[CNT_W-1:0] != '0));

    // R3: high time of a valid cycle cannot exceed its period
    a_r3_high_le_period: assert property (@(posedge clk) disable iff (!rst_n)
        period_reg[CNT_W] |-> (high_reg[CNT_W-1:0] <= period_reg[CNT_W-1:0]));

    // R7: a read strobe drops the flag and keeps the counts
    a_r7_clear_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !done) |=> (!period_reg[CNT_W]
                               && $stable(period_reg[CNT_W-1:0])
                               && $stable(high_reg)));

    // R8: with the sensor switched off the results are frozen
    a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !rd_clr) |=> ($stable(period_reg) && $stable(high_reg)));

endmodule

// File: tb/test_ircs_carrier_sense.sv
module test_ircs_carrier_sense;

    localparam int TB_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_raw = 1'b0;
    logic       det_en = 1'b0;
    logic       demod_en = 1'b0;
    logic       rd_clr = 1'b0;
    logic [7:0] period_reg;
    logic [7:0] high_reg;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ircs_carrier_sense #(.TICK_DIV(TB_DIV), .CNT_W(7), .SYNC_STAGES(2)) i_ircs_carrier_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_raw     (ir_raw),
        .det_en     (det_en),
        .demod_en   (demod_en),
        .rd_clr     (rd_clr),
        .period_reg (period_reg),
        .high_reg   (high_reg)
    );

    function automatic logic [7:0] exp_period(int n);
        int c = n / TB_DIV;
        if (c > 127)  return 8'h7F;
        if (c == 0)   return 8'h00;
        return {1'b1, 7'(c)};
    endfunction

    function automatic logic [7:0] exp_high(int h);
        int c = h / TB_DIV;
        if (c > 127) c = 127;
        return {1'b0, 7'(c)};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one carrier cycle: rising edge, h cycles high, n-h low, closing rise
    task automatic run_cycle(int n, int h);
        ir_raw = 1'b1;
        repeat (h) @(negedge clk);
        ir_raw = 1'b0;
        repeat (n - h) @(negedge clk);
        ir_raw = 1'b1;
    endtask

    task automatic measure(int n, int h, string req);
        ir_raw = 1'b0;
        repeat (4) @(negedge clk);
        run_cycle(n, h);
        repeat (4) @(negedge clk);
        check(req, period_reg, exp_period(n));
        check(req, high_reg, exp_high(h));
        ir_raw = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep_p;
        logic [7:0] keep_h;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 period", period_reg, 8'h00);
        check("R1 high", high_reg, 8'h00);

        det_en = 1'b1;
        demod_en = 1'b1;

        // directed: ordinary cycle and its duty
        measure(80, 20, "R2/R3 directed");
        measure(41, 40, "R2/R3 long high");

        // R7: read strobe clears flag, counts stay
        keep_p = period_reg;
        keep_h = high_reg;
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        check("R7 period", period_reg, {1'b0, keep_p[6:0]});
        check("R7 high", high_reg, keep_h);

        // R5: sub-tick period reads as no carrier
        measure(80, 20, "R2 setup");
        measure(3, 1, "R5 zero period");

        // R6: overflow of period, then of both counts
        measure(600, 300, "R6 period overflow");
        measure(1200, 1100, "R6 high saturate");

        // R8: each enable low freezes results
        measure(80, 20, "R2 setup");
        keep_p = period_reg;
        keep_h = high_reg;
        det_en = 1'b0;
        ir_raw = 1'b0;
        repeat (4) @(negedge clk);
        run_cycle(60, 30);
        repeat (4) @(negedge clk);
        check("R8 det_en period", period_reg, keep_p);
        check("R8 det_en high", high_reg, keep_h);
        det_en = 1'b1;
        demod_en = 1'b0;
        ir_raw = 1'b0;
        repeat (4) @(negedge clk);
        run_cycle(100, 10);
        repeat (4) @(negedge clk);
        check("R8 demod_en period", period_reg, keep_p);
        check("R8 demod_en high", high_reg, keep_h);

        // R4 + R9: re-enable, first edge only arms, then count latency
        ir_raw = 1'b0;
        repeat (4) @(negedge clk);
        demod_en = 1'b1;
        repeat (2) @(negedge clk);
        run_cycle(40, 10);
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R4 arming edge", period_reg, keep_p);
        check("R9 early", high_reg, keep_h);
        @(posedge clk);
        #1;
        check("R9 period on time", period_reg, exp_period(40));
        check("R9 high on time", high_reg, exp_high(10));
        @(negedge clk);
        ir_raw = 1'b0;

        // random cycles
        for (int i = 0; i < 24; i++) begin
            int n = 2 + int'($urandom % 700);
            int h = 1 + int'($urandom % (n - 1));
            measure(n, h, "R2/R3 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule